// File: doc/BRIEF.md
# Configurable PLD Macrocell Register

This block is one logic cell of a small programmable logic device. Eight sum-of-products terms arrive from the AND array, split into a lower and an upper group of four. Either group can be lent to a neighbouring cell, and a neighbour's group can be borrowed in. The summed terms pass through a polarity stage. They then feed a storage element whose type is chosen by configuration: D, T, JK or SR. The storage element can also be bypassed so the cell acts as plain combinational logic.

Eight further product terms form four control signals, each the OR of its own pair: output enable, preset, clear and a private clock. The register advances on the global clock, or only on cycles where the private clock term has risen. The cell drives a pin value with its enable. It also returns two feedbacks to the array: an internal one taken from the cell value, and a pin one that reflects the external pin when the driver is off. This lets a buried register reuse its pin as an input.

Top module: `pld_cell`

## Requirements
- R1: While `rst_n` is low, the stored bit is 0, so a registered cell with polarity 0 shows 0 on `fb_int` and `pin_out`.
- R2: In D mode (`cfg_kind`=1, and also for the unused codes 5 to 7), each global clock edge stores (lower-group OR | upper-group OR | `borrow_prev` | `borrow_next`) XOR `cfg_invert`. The lower group is `pt_logic[3:0]` and the upper group is `pt_logic[7:4]`.
- R3: With `cfg_invert`=1, the value presented to the storage element is the complement of the term sum.
- R4: With `cfg_lend_lo`=1, `lend_prev` equals the OR of the lower group and that group is removed from the cell's own sum. `cfg_lend_hi` does the same for the upper group and `lend_next`. A group that is not lent gives 0 on its lend output.
- R5: In T mode (`cfg_kind`=2), the stored bit inverts on an edge when the polarity-adjusted sum is 1, and holds when it is 0.
- R6: In JK mode (`cfg_kind`=3), J is (lower group | `borrow_prev`) XOR `cfg_invert` and K is (upper group | `borrow_next`) XOR `cfg_invert`. The effects are: J alone sets, K alone clears, neither holds, both toggle.
- R7: In SR mode (`cfg_kind`=4), with S and R formed as J and K are in R6: S alone sets, R alone clears, and both or neither holds.
- R8: In bypass (`cfg_kind`=0), `pin_out` and `fb_int` follow the polarity-adjusted sum within the same cycle, with no clock edge.
- R9: Preset is `pt_ctrl[2]|pt_ctrl[3]` and clear is `pt_ctrl[4]|pt_ctrl[5]`. Either one changes a registered cell's output at once, without a clock edge. Clear wins over preset. The forced value stays after release until the register is next loaded.
- R10: With `cfg_pclk_sel`=1, the register loads only at a global clock edge where the private clock `pt_ctrl[6]|pt_ctrl[7]` is 1 and was 0 at the previous edge. Otherwise it holds.
- R11: `pin_oe` is `pt_ctrl[0]|pt_ctrl[1]`. `fb_int` always carries the cell value. `fb_pin` equals `pin_out` when `pin_oe` is 1 and `pin_in` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| cfg_kind | input | 3 | Storage type: 0 bypass, 1 D, 2 T, 3 JK, 4 SR |
| cfg_invert | input | 1 | Polarity select, 1 complements the sum |
| cfg_pclk_sel | input | 1 | 1 selects the private clock term |
| cfg_lend_lo | input | 1 | Lend the lower term group to the previous cell |
| cfg_lend_hi | input | 1 | Lend the upper term group to the next cell |
| pt_logic | input | 8 | Logic product terms, two groups of four |
| pt_ctrl | input | 8 | Control terms: pairs for enable, preset, clear, private clock |
| borrow_prev | input | 1 | Group sum lent in by the previous cell |
| borrow_next | input | 1 | Group sum lent in by the next cell |
| pin_in | input | 1 | Value seen on the external pin |
| lend_prev | output | 1 | Lower group sum lent to the previous cell |
| lend_next | output | 1 | Upper group sum lent to the next cell |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_int | output | 1 | Internal feedback to the array |
| fb_pin | output | 1 | Pin feedback to the array |

## Verification
The assertions assume the configuration inputs are static during an observed window. They also assume the control terms stay steady between global clock edges, because preset, clear and the private clock are sampled as levels at each edge. The stimulus changes terms and configuration only on the falling clock edge. It changes the mode only after a clear pulse has put the register in a known state, so every property sees clean edge-to-edge behaviour.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [2:0] {
    CK_BYPASS = 3'd0,
    CK_D      = 3'd1,
    CK_T      = 3'd2,
    CK_JK     = 3'd3,
    CK_SR     = 3'd4
  } cell_kind_e;

  // Next stored bit for each storage type; a is D/T/J/S, b is K/R
  function automatic logic next_bit(cell_kind_e kind, logic q, logic a, logic b);
    logic r;
    case (kind)
      CK_T:    r = q ^ a;
      CK_JK:   r = (a & ~q) | (~b & q);
      CK_SR: begin
        if (a & ~b)      r = 1'b1;
        else if (b & ~a) r = 1'b0;
        else             r = q;
      end
      default: r = a;
    endcase
    return r;
  endfunction

  // True when the kind takes two separate inputs
  function automatic logic two_input(cell_kind_e kind);
    return (kind == CK_JK) || (kind == CK_SR);
  endfunction

endpackage

// File: rtl/pld_cell_sum.sv
module pld_cell_sum #(
  parameter int GRP_TERMS = 4
) (
  input  logic [2*GRP_TERMS-1:0] pt_logic,
  input  logic                   lend_lo,
  input  logic                   lend_hi,
  input  logic                   borrow_prev,
  input  logic                   borrow_next,
  input  logic                   invert,
  output logic                   lend_prev,
  output logic                   lend_next,
  output logic                   in_a,
  output logic                   in_b,
  output logic                   data
);
  localparam int N_GRP = 2;

  logic [N_GRP-1:0] grp_or;
  logic [N_GRP-1:0] grp_lent;
  logic [N_GRP-1:0] grp_kept;

  assign grp_lent = {lend_hi, lend_lo};

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_or[g]   = |pt_logic[g*GRP_TERMS +: GRP_TERMS];
    assign grp_kept[g] = grp_or[g] & ~grp_lent[g];
  end

  assign lend_prev = grp_or[0] & lend_lo;
  assign lend_next = grp_or[1] & lend_hi;

  logic sum_a, sum_b;
  assign sum_a = grp_kept[0] | borrow_prev;
  assign sum_b = grp_kept[1] | borrow_next;

  assign in_a = sum_a ^ invert;
  assign in_b = sum_b ^ invert;
  assign data = (sum_a | sum_b) ^ invert;
endmodule

// File: rtl/pld_cell_ctrl.sv
module pld_cell_ctrl #(
  parameter int PAIR_TERMS = 2,
  parameter int N_SIG      = 4
) (
  input  logic [N_SIG*PAIR_TERMS-1:0] pt_ctrl,
  output logic [N_SIG-1:0]            ctrl_sig
);
  for (genvar c = 0; c < N_SIG; c++) begin : g_sig
    assign ctrl_sig[c] = |pt_ctrl[c*PAIR_TERMS +: PAIR_TERMS];
  end
endmodule

// File: rtl/pld_cell_store.sv
module pld_cell_store
  import pld_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cell_kind_e kind,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       data,
  input  logic       preset,
  input  logic       clear,
  input  logic       use_pclk,
  input  logic       pclk,
  output logic       tick,
  output logic       cell_val
);
  logic q_reg;
  logic pclk_d;
  logic q_live;
  logic in_first;
  logic q_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_d <= 1'b0;
    else        pclk_d <= pclk;
  end

  assign tick     = use_pclk ? (pclk & ~pclk_d) : 1'b1;
  assign q_live   = clear ? 1'b0 : (preset ? 1'b1 : q_reg);
  assign in_first = two_input(kind) ? in_a : data;
  assign q_next   = next_bit(kind, q_live, in_first, in_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_reg <= 1'b0;
    else if (clear)  q_reg <= 1'b0;
    else if (preset) q_reg <= 1'b1;
    else if (tick)   q_reg <= q_next;
  end

  assign cell_val = (kind == CK_BYPASS) ? data : q_live;

  AST_CLEAR_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q_reg == 1'b0)); // R9

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear && !preset) |=> $stable(q_reg)); // R10

  AST_T_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_T && tick && data && !clear && !preset) |=> (q_reg != $past(q_reg))); // R5

  AST_PCLK_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (use_pclk && tick) |=> (!use_pclk || !tick)); // R10
endmodule

// File: rtl/pld_cell.sv
module pld_cell
  import pld_cell_pkg::*;
#(
  parameter int GRP_TERMS  = 4,
  parameter int PAIR_TERMS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              cfg_kind,
  input  logic                    cfg_invert,
  input  logic                    cfg_pclk_sel,
  input  logic                    cfg_lend_lo,
  input  logic                    cfg_lend_hi,
  input  logic [2*GRP_TERMS-1:0]  pt_logic,
  input  logic [4*PAIR_TERMS-1:0] pt_ctrl,
  input  logic                    borrow_prev,
  input  logic                    borrow_next,
  input  logic                    pin_in,
  output logic                    lend_prev,
  output logic                    lend_next,
  output logic                    pin_out,
  output logic                    pin_oe,
  output logic                    fb_int,
  output logic                    fb_pin
);
  localparam int N_CTRL  = 4;
  localparam int IDX_OE  = 0;
  localparam int IDX_PRE = 1;
  localparam int IDX_CLR = 2;
  localparam int IDX_PCK = 3;

  cell_kind_e       kind;
  logic [N_CTRL-1:0] ctrl_sig;
  logic in_a, in_b, data;
  logic tick, cell_val;

  assign kind = cell_kind_e'(cfg_kind);

  pld_cell_sum #(.GRP_TERMS(GRP_TERMS)) u_sum (
    .pt_logic    (pt_logic),
    .lend_lo     (cfg_lend_lo),
    .lend_hi     (cfg_lend_hi),
    .borrow_prev (borrow_prev),
    .borrow_next (borrow_next),
    .invert      (cfg_invert),
    .lend_prev   (lend_prev),
    .lend_next   (lend_next),
    .in_a        (in_a),
    .in_b        (in_b),
    .data        (data)
  );

  pld_cell_ctrl #(.PAIR_TERMS(PAIR_TERMS), .N_SIG(N_CTRL)) u_ctrl (
    .pt_ctrl  (pt_ctrl),
    .ctrl_sig (ctrl_sig)
  );

  pld_cell_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .in_a     (in_a),
    .in_b     (in_b),
    .data     (data),
    .preset   (ctrl_sig[IDX_PRE]),
    .clear    (ctrl_sig[IDX_CLR]),
    .use_pclk (cfg_pclk_sel),
    .pclk     (ctrl_sig[IDX_PCK]),
    .tick     (tick),
    .cell_val (cell_val)
  );

  assign fb_int  = cell_val;
  assign pin_out = cell_val;
  assign pin_oe  = ctrl_sig[IDX_OE];
  assign fb_pin  = pin_oe ? pin_out : pin_in;

  AST_PIN_FB_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (fb_pin == fb_int)); // R11

  AST_CLEAR_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sig[IDX_CLR] && kind != CK_BYPASS) |-> (fb_int == 1'b0)); // R9
endmodule

// File: tb/sim_pld_cell.sv
`timescale 1ns/1ps
module sim_pld_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_kind = 3'd1;
  logic       cfg_invert = 1'b0, cfg_pclk_sel = 1'b0;
  logic       cfg_lend_lo = 1'b0, cfg_lend_hi = 1'b0;
  logic [7:0] pt_logic = 8'h00, pt_ctrl = 8'h00;
  logic       borrow_prev = 1'b0, borrow_next = 1'b0, pin_in = 1'b0;
  logic       lend_prev, lend_next, pin_out, pin_oe, fb_int, fb_pin;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pld_cell u0 (.*);

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_reg();
    drive_edge();
    pt_ctrl = 8'h10;
    step();
    drive_edge();
    pt_ctrl = 8'h00;
  endtask

  task automatic t_reset();
    pt_logic = 8'hFF;
    #1;
    check("R1 fb_int in reset", fb_int, 1'b0);
    check("R1 pin_out in reset", pin_out, 1'b0);
    drive_edge();
    rst_n = 1'b1;
    pt_logic = 8'h00;
  endtask

  task automatic t_dmode();
    logic [7:0] pats [4] = '{8'h00, 8'h02, 8'h40, 8'h00};
    cfg_kind = 3'd1;
    foreach (pats[i]) begin
      drive_edge();
      pt_logic = pats[i];
      step();
      check("R2 D load", fb_int, (pats[i] != 8'h00));
    end
    drive_edge();
    borrow_prev = 1'b1;
    step();
    check("R2 D borrowed", fb_int, 1'b1);
    drive_edge();
    borrow_prev = 1'b0;
    cfg_kind = 3'd6;
    pt_logic = 8'h00;
    borrow_next = 1'b1;
    step();
    check("R2 code 6 as D", fb_int, 1'b1);
    drive_edge();
    borrow_next = 1'b0;
    cfg_kind = 3'd1;
    step();
  endtask

  task automatic t_polarity();
    drive_edge();
    cfg_invert = 1'b1;
    pt_logic = 8'h00;
    step();
    check("R3 inverted zero", fb_int, 1'b1);
    drive_edge();
    pt_logic = 8'h81;
    step();
    check("R3 inverted one", fb_int, 1'b0);
    drive_edge();
    cfg_invert = 1'b0;
  endtask

  task automatic t_lend();
    drive_edge();
    cfg_lend_lo = 1'b1;
    pt_logic = 8'h0F;
    #1;
    check("R4 lend_prev", lend_prev, 1'b1);
    check("R4 lend_next idle", lend_next, 1'b0);
    step();
    check("R4 lent lo excluded", fb_int, 1'b0);
    drive_edge();
    cfg_lend_lo = 1'b0;
    cfg_lend_hi = 1'b1;
    pt_logic = 8'hF0;
    #1;
    check("R4 lend_next", lend_next, 1'b1);
    check("R4 lend_prev idle", lend_prev, 1'b0);
    step();
    check("R4 lent hi excluded", fb_int, 1'b0);
    drive_edge();
    cfg_lend_hi = 1'b0;
    pt_logic = 8'h0F;
    step();
    check("R4 kept group used", fb_int, 1'b1);
    drive_edge();
    pt_logic = 8'h00;
  endtask

  task automatic t_toggle();
    logic exp;
    clear_reg();
    cfg_kind = 3'd2;
    pt_logic = 8'h01;
    exp = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      exp = ~exp;
      check("R5 T toggle", fb_int, exp);
    end
    drive_edge();
    pt_logic = 8'h00;
    step();
    check("R5 T hold", fb_int, exp);
  endtask

  task automatic t_jk();
    logic [1:0] jk [5] = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b11};
    logic       ex [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    clear_reg();
    cfg_kind = 3'd3;
    foreach (jk[i]) begin
      drive_edge();
      pt_logic = {3'b000, jk[i][0], 3'b000, jk[i][1]};
      step();
      check("R6 JK", fb_int, ex[i]);
    end
  endtask

  task automatic t_sr();
    logic [1:0] sr [5] = '{2'b10, 2'b11, 2'b01, 2'b11, 2'b00};
    logic       ex [5] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    clear_reg();
    cfg_kind = 3'd4;
    foreach (sr[i]) begin
      drive_edge();
      pt_logic = {sr[i][0], 3'b000, sr[i][1], 3'b000};
      step();
      check("R7 SR", fb_int, ex[i]);
    end
  endtask

  task automatic t_bypass();
    drive_edge();
    cfg_kind = 3'd0;
    pt_logic = 8'h00;
    #1;
    check("R8 bypass zero", pin_out, 1'b0);
    pt_logic = 8'h10;
    #1;
    check("R8 bypass follows", pin_out, 1'b1);
    cfg_invert = 1'b1;
    #1;
    check("R8 bypass inverted", fb_int, 1'b0);
    cfg_invert = 1'b0;
    pt_logic = 8'h00;
  endtask

  task automatic t_preclr();
    clear_reg();
    cfg_kind = 3'd2;
    pt_logic = 8'h00;
    pt_ctrl = 8'h08;
    #1;
    check("R9 preset immediate", pin_out, 1'b1);
    step();
    drive_edge();
    pt_ctrl = 8'h00;
    step();
    check("R9 preset retained", pin_out, 1'b1);
    drive_edge();
    pt_ctrl = 8'h24;
    #1;
    check("R9 clear wins", pin_out, 1'b0);
    step();
    drive_edge();
    pt_ctrl = 8'h00;
    step();
    check("R9 clear retained", pin_out, 1'b0);
  endtask

  task automatic t_pclk();
    clear_reg();
    cfg_kind = 3'd1;
    cfg_pclk_sel = 1'b1;
    pt_logic = 8'h01;
    step();
    step();
    check("R10 no private edge", fb_int, 1'b0);
    drive_edge();
    pt_ctrl = 8'h40;
    step();
    check("R10 private rise loads", fb_int, 1'b1);
    drive_edge();
    pt_logic = 8'h00;
    step();
    check("R10 level high holds", fb_int, 1'b1);
    drive_edge();
    pt_ctrl = 8'h00;
    step();
    check("R10 fall holds", fb_int, 1'b1);
    drive_edge();
    pt_ctrl = 8'h80;
    step();
    check("R10 second rise loads", fb_int, 1'b0);
    drive_edge();
    pt_ctrl = 8'h00;
    cfg_pclk_sel = 1'b0;
  endtask

  task automatic t_io();
    clear_reg();
    cfg_kind = 3'd1;
    pt_logic = 8'h00;
    pin_in = 1'b1;
    pt_ctrl = 8'h02;
    #1;
    check("R11 oe on", pin_oe, 1'b1);
    check("R11 pin fb driven", fb_pin, 1'b0);
    pt_ctrl = 8'h00;
    #1;
    check("R11 oe off", pin_oe, 1'b0);
    check("R11 pin fb external", fb_pin, 1'b1);
    check("R11 int fb cell", fb_int, 1'b0);
    pin_in = 1'b0;
    #1;
    check("R11 pin fb follows pin", fb_pin, 1'b0);
  endtask

  initial begin
    t_reset();
    t_dmode();
    t_polarity();
    t_lend();
    t_toggle();
    t_jk();
    t_sr();
    t_bypass();
    t_preclr();
    t_pclk();
    t_io();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule